// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the per-port status and control word of one root port of a USB 2.0 host controller. The word has four fields: port power, device present, connect-change flag and port enable. Software reads and writes the word over a simple single-register bus. Hardware events update the status fields. These events are a line-state connect indication, a pulse that marks the end of a port reset (with a flag telling whether a high-speed device answered), and a fault pulse.

Software can never turn the enable on. It goes high only when a port reset ends with a high-speed device found. A disconnect, a fault or a software write of 0 takes it low again. The change flag is sticky and is cleared by writing 1 to it. While port power is off, all three status fields are held at zero. A gate output follows the enable, so downstream data flows only on an enabled port. Reset signalling is produced outside this block and is not gated by it.

The bus reset `rst_n` is expected to be asserted asynchronously and released synchronously to `clk` by the reset tree upstream.

Top module: `usb_port_stsctl`

## Requirements
- R1: After reset, every bit of the read word is 0 and `dn_pass` is 0.
- R2: With power on, bit 0 (device present) reads 1 when a device is attached and 0 when none is. A level change on `line_conn` reaches bit 0 on the third rising clock edge after the change is first sampled, never earlier. The change passes through a two-flop synchronizer and then the status register.
- R3: Bit 1 (connect change) becomes 1 on the same edge at which bit 0 changes while power is on. If it is already 1 when bit 0 changes again, it stays 1.
- R4: A write with bit 1 set clears the connect-change flag. A write with bit 1 clear leaves it unchanged. Writes never alter bit 0.
- R5: If bit 0 changes on the same edge as a write that clears bit 1, bit 1 ends at 1.
- R6: A write with bit 2 set never sets the port enable. A write with bit 2 clear clears it.
- R7: Bit 2 (port enable) becomes 1 only on an edge where `prst_done` and `prst_hs` are both 1. A reset completion with `prst_hs` at 0 leaves it at 0.
- R8: A `port_fault` pulse clears bit 2 at the next edge. A disconnect (bit 0 going from 1 to 0) clears bit 2 on the same edge that sets bit 1.
- R9: Writing 0 to bit 12 clears bits 0, 1 and 2 on the same edge. While bit 12 is 0, those three bits stay 0 whatever the line, reset and fault inputs do.
- R10: Bit 12 (port power) reads back the last value written to it. All bits other than 0, 1, 2 and 12 always read 0.
- R11: `dn_pass` is 1 exactly when bit 2 reads 1.
- R12: When a fault or a disable condition falls on the same edge as a high-speed reset completion, bit 2 ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr_en | input | 1 | Write strobe for the port word |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Current port word |
| line_conn | input | 1 | Asynchronous device-attached indication from the line monitor |
| prst_done | input | 1 | One-cycle pulse at the end of a port reset |
| prst_hs | input | 1 | High-speed device seen during that reset |
| port_fault | input | 1 | One-cycle fault pulse |
| dn_pass | output | 1 | Downstream data allowed |

## Verification
The bench aims at edges where several events land together. One case is a connect change landing with a clear-by-write: a design with the wrong priority would lose the change. Another is a fault landing with a high-speed reset completion: a design with the wrong priority would leave the port enabled after a fault. The bench also writes 1 to the enable and 0 to the change bit, which a design using plain read-write fields would obey. It counts the synchronizer latency edge by edge, since a missing or extra flop shifts bit 0 by a cycle. It toggles the line and pulses faults and resets while power is off, where a design without the power gate would collect stale status. A long pseudo-random sweep then compares every field on every cycle with a cycle model written from the requirements.

// File: rtl/usbps_pkg.sv
package usbps_pkg;
  // Field positions; software decodes these.
  localparam int unsigned CCS_POS = 0;
  localparam int unsigned CSC_POS = 1;
  localparam int unsigned PEN_POS = 2;
  localparam int unsigned PWR_POS = 12;
endpackage

// File: rtl/usbps_conn_sync.sv
module usbps_conn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic pwr_cur,
  input  logic pwr_nxt,
  output logic ccs_o,
  output logic edge_o,
  output logic disc_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              ccs_q;
  logic              ccs_d;
  logic              sync_w;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign chain_d[gi] = line_i;
      end else begin : g_next
        assign chain_d[gi] = chain_q[gi-1];
      end
    end
  endgenerate

  assign sync_w = chain_q[STAGES-1];

  always_comb begin
    edge_o = pwr_cur && (sync_w != ccs_q);
    disc_o = edge_o && ccs_q;
    ccs_d  = (pwr_cur && pwr_nxt) ? sync_w : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      ccs_q   <= 1'b0;
    end else begin
      chain_q <= chain_d;
      ccs_q   <= ccs_d;
    end
  end

  assign ccs_o = ccs_q;
endmodule

// File: rtl/usbps_chg_flag.sv
module usbps_chg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_nxt,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    if (!pwr_nxt)     flag_d = 1'b0;
    else if (set_i)   flag_d = 1'b1;
    else if (clr_i)   flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usbps_port_en.sv
module usbps_port_en (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_nxt,
  input  logic clr_i,
  input  logic set_i,
  output logic en_o
);
  logic en_q;
  logic en_d;

  always_comb begin
    if (!pwr_nxt)    en_d = 1'b0;
    else if (clr_i)  en_d = 1'b0;
    else if (set_i)  en_d = 1'b1;
    else             en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/usb_port_stsctl.sv
module usb_port_stsctl #(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             line_conn,
  input  logic             prst_done,
  input  logic             prst_hs,
  input  logic             port_fault,
  output logic             dn_pass
);
  import usbps_pkg::*;

  logic pwr_q;
  logic pwr_d;
  logic ccs_w;
  logic edge_w;
  logic disc_w;
  logic csc_w;
  logic pen_w;
  logic chg_clr_w;
  logic en_clr_w;
  logic en_set_w;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_comb begin
    pwr_d     = reg_wr_en ? reg_wdata[PWR_POS] : pwr_q;
    chg_clr_w = reg_wr_en && reg_wdata[CSC_POS];
    en_clr_w  = disc_w || port_fault || (reg_wr_en && !reg_wdata[PEN_POS]);
    en_set_w  = prst_done && prst_hs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b0;
    else        pwr_q <= pwr_d;
  end

  usbps_conn_sync #(.STAGES(SYNC_STAGES)) u_conn (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_conn),
    .pwr_cur (pwr_q),
    .pwr_nxt (pwr_d),
    .ccs_o   (ccs_w),
    .edge_o  (edge_w),
    .disc_o  (disc_w)
  );

  usbps_chg_flag u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_nxt (pwr_d),
    .set_i   (edge_w),
    .clr_i   (chg_clr_w),
    .flag_o  (csc_w)
  );

  usbps_port_en u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_nxt (pwr_d),
    .clr_i   (en_clr_w),
    .set_i   (en_set_w),
    .en_o    (pen_w)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[CCS_POS] = ccs_w;
    reg_rdata[CSC_POS] = csc_w;
    reg_rdata[PEN_POS] = pen_w;
    reg_rdata[PWR_POS] = pwr_q;
  end

  assign dn_pass = pen_w;
endmodule

// File: rtl/usb_port_stsctl_chk.sv
module usb_port_stsctl_chk #(
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             prst_done,
  input logic             prst_hs,
  input logic             port_fault
);
  import usbps_pkg::*;

  // R9
  pwr_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[PWR_POS] |-> (reg_rdata[PEN_POS:CCS_POS] == 3'b000));

  // R3
  chg_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[PWR_POS] && $past(reg_rdata[PWR_POS]) &&
     (reg_rdata[CCS_POS] != $past(reg_rdata[CCS_POS]))) |-> reg_rdata[CSC_POS]);

  // R7
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[PEN_POS]) |-> $past(prst_done && prst_hs));

  // R8
  fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(port_fault) |-> !reg_rdata[PEN_POS]);

  // R4
  chg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[CSC_POS]) |->
      ($past(reg_wr_en && reg_wdata[CSC_POS]) || !reg_rdata[PWR_POS]));
endmodule

bind usb_port_stsctl usb_port_stsctl_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .prst_done  (prst_done),
  .prst_hs    (prst_hs),
  .port_fault (port_fault)
);

// File: tb/usb_port_stsctl_bench.sv
`timescale 1ns/1ps
module usb_port_stsctl_bench;
  localparam int W = 32;
  localparam logic [W-1:0] PWR = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n;
  logic wr;
  logic [W-1:0] wd;
  logic [W-1:0] rd;
  logic line, done, hs, flt, dn;

  int checks = 0;
  int errors = 0;

  // cycle model built from the requirements
  logic m_s1, m_s2, m_ccs, m_csc, m_pen, m_pwr;

  always #2.5 clk = ~clk;

  usb_port_stsctl u_usb_port_stsctl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_wdata(wd),
    .reg_rdata(rd), .line_conn(line), .prst_done(done),
    .prst_hs(hs), .port_fault(flt), .dn_pass(dn)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic pn, ed, dc;
    pn = wr ? wd[12] : m_pwr;
    ed = m_pwr && (m_s2 != m_ccs);
    dc = ed && m_ccs;
    m_csc = !pn ? 1'b0 : ed ? 1'b1 : (wr && wd[1]) ? 1'b0 : m_csc;
    m_pen = !pn ? 1'b0 : (dc || flt || (wr && !wd[2])) ? 1'b0 :
            (done && hs) ? 1'b1 : m_pen;
    m_ccs = (pn && m_pwr) ? m_s2 : 1'b0;
    m_s2  = m_s1;
    m_s1  = line;
    m_pwr = pn;
  endtask

  task automatic cmp_all();
    chk("R2 present", {31'd0, rd[0]}, {31'd0, m_ccs});
    chk("R3 change",  {31'd0, rd[1]}, {31'd0, m_csc});
    chk("R7 enable",  {31'd0, rd[2]}, {31'd0, m_pen});
    chk("R10 power",  {31'd0, rd[12]}, {31'd0, m_pwr});
    chk("R10 spare",  rd & ~32'h0000_1007, 32'd0);
    chk("R11 gate",   {31'd0, dn}, {31'd0, rd[2]});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    cmp_all();
    wr = 1'b0; done = 1'b0; flt = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; wr = 1'b0; wd = '0; line = 1'b0; done = 1'b0; hs = 1'b0; flt = 1'b0;
    {m_s1, m_s2, m_ccs, m_csc, m_pen, m_pwr} = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 word", rd, 32'd0);
    chk("R1 gate", {31'd0, dn}, 32'd0);
    rst_n = 1'b1;

    // power on
    wr = 1'b1; wd = PWR; cyc();
    chk("R10 power readback", rd, PWR);

    // synchronizer latency
    line = 1'b1; cyc(); cyc();
    chk("R2 not before third edge", {31'd0, rd[0]}, 32'd0);
    cyc();
    chk("R2 present after third edge", rd & 32'h3, 32'h3);

    // write 0 to change bit, write 1 to present bit
    wr = 1'b1; wd = PWR | 32'h5; cyc();
    chk("R4 write zero keeps change", {31'd0, rd[1]}, 32'd1);
    chk("R4 present unchanged", {31'd0, rd[0]}, 32'd1);
    wr = 1'b1; wd = PWR | 32'h6; cyc();
    chk("R4 write one clears change", {31'd0, rd[1]}, 32'd0);

    // enable via reset completion
    done = 1'b1; hs = 1'b0; cyc();
    chk("R7 full-speed reset no enable", {31'd0, rd[2]}, 32'd0);
    done = 1'b1; hs = 1'b1; cyc();
    chk("R7 high-speed reset enables", {31'd0, rd[2]}, 32'd1);
    chk("R11 gate open", {31'd0, dn}, 32'd1);
    wr = 1'b1; wd = PWR | 32'h4; cyc();
    chk("R6 write one keeps enable", {31'd0, rd[2]}, 32'd1);
    wr = 1'b1; wd = PWR; cyc();
    chk("R6 write zero disables", {31'd0, rd[2]}, 32'd0);
    done = 1'b1; hs = 1'b1; cyc();

    // disconnect collides with clear of change bit
    line = 1'b0; cyc(); cyc();
    wr = 1'b1; wd = PWR | 32'h6; cyc();
    chk("R5 set beats clear", {31'd0, rd[1]}, 32'd1);
    chk("R8 disconnect disables", {31'd0, rd[2]}, 32'd0);
    chk("R2 absent", {31'd0, rd[0]}, 32'd0);

    // reconnect, then fault with reset completion
    line = 1'b1; cyc(); cyc(); cyc();
    done = 1'b1; hs = 1'b1; flt = 1'b1; cyc();
    chk("R12 fault beats enable", {31'd0, rd[2]}, 32'd0);
    done = 1'b1; hs = 1'b1; cyc();
    flt = 1'b1; cyc();
    chk("R8 fault disables", {31'd0, rd[2]}, 32'd0);
    done = 1'b1; hs = 1'b1; cyc();

    // power off
    wr = 1'b1; wd = 32'h0000_0007; cyc();
    chk("R9 power off clears", rd, 32'd0);
    for (int i = 0; i < 8; i++) begin
      line = ~line; done = 1'b1; hs = 1'b1; cyc();
      chk("R9 held while unpowered", rd, 32'd0);
    end

    // pseudo-random sweep
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr   = (lf[3:1] == 3'd0);
      wd   = {$urandom} & 32'hFFFF_EFF8;
      wd[1] = lf[4]; wd[2] = lf[5]; wd[12] = lf[6] | lf[7] | lf[9];
      wd[0] = lf[8];
      done = lf[8] & lf[9];
      hs   = lf[10];
      flt  = lf[11] & lf[12] & lf[13];
      if (lf[14] & lf[15] & lf[0]) line = ~line;
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule